// File: doc/BRIEF.md
# Banked General Register File

This block holds the sixteen 32-bit general registers of a small CPU core. The low eight architectural registers exist twice, as two physical banks. A bank-select input, owned by the status register outside this block, decides which bank the core sees. The upper eight registers are a single physical set that both bank settings see. In total there are 24 physical 32-bit registers.

Ordinary instructions use two combinational read ports and one synchronous write port. A separate output always carries register 0 of the current bank, because the indexed addressing modes use that register as their index. For DSP-style data moves, a set of short select codes picks the address and index registers for X memory, Y memory and single-data transfers. A debug port can read or write either bank of registers 0 to 7 directly, whatever the bank-select value.

Top module: `banked_regfile`

## Requirements
- R1: Reset (active-low `rst_n`) clears all 24 physical registers to zero: both banks of registers 0–7 and the shared registers 8–15.
- R2: `rd_a_data` and `rd_b_data` return the visible register named by their 4-bit address. For addresses 0–7, bank 0 is visible when `bank_sel` is 0 and bank 1 when it is 1. Addresses 8–15 read the shared registers. A change of `bank_sel` shows on the outputs in the same cycle, with no clock edge needed.
- R3: `r0_index` always carries register 0 of the bank chosen by `bank_sel`.
- R4: A write with `wr_en` high to address 0–7 updates only the bank chosen by `bank_sel` at that clock edge; the other bank keeps its value. A write to address 8–15 is seen from both bank settings.
- R5: Every read output (A, B, `r0_index` and the six DSP outputs) forwards `wr_data` when `wr_en` is high and `wr_addr` equals the register that output selects.
- R6: `x_addr` returns register 4 when `x_sel` is 0 and register 5 when it is 1. `x_index` always returns register 8.
- R7: `y_addr` returns register 6 when `y_sel` is 0 and register 7 when it is 1. `y_index` always returns register 9.
- R8: `s_addr` returns register 2 + `s_sel` (codes 0..3 select registers 2..5). `s_index` always returns register 8.
- R9: `dbg_rdata` returns the stored value of register `dbg_reg` (0–7) in bank `dbg_bank` (0 = bank 0, 1 = bank 1) with no forwarding. When `dbg_we` is high, that register is written at the clock edge, whatever `bank_sel` is.
- R10: If a debug write and a normal write target the same physical register in the same cycle, the debug value is stored.
- R11: When `wr_en` and `dbg_we` are both low, no register changes, whatever the values on `wr_addr`, `wr_data` and `dbg_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_sel | input | 1 | Bank select for registers 0–7 |
| wr_en | input | 1 | Write enable for the instruction write port |
| wr_addr | input | 4 | Write register number |
| wr_data | input | 32 | Write data |
| rd_a_addr | input | 4 | Read port A register number |
| rd_a_data | output | 32 | Read port A data |
| rd_b_addr | input | 4 | Read port B register number |
| rd_b_data | output | 32 | Read port B data |
| r0_index | output | 32 | Register 0 of the current bank |
| x_sel | input | 1 | X address register code |
| x_addr | output | 32 | X address register value |
| x_index | output | 32 | X index register value |
| y_sel | input | 1 | Y address register code |
| y_addr | output | 32 | Y address register value |
| y_index | output | 32 | Y index register value |
| s_sel | input | 2 | Single-data address register code |
| s_addr | output | 32 | Single-data address register value |
| s_index | output | 32 | Single-data index register value |
| dbg_we | input | 1 | Debug write enable |
| dbg_bank | input | 1 | Debug bank number |
| dbg_reg | input | 3 | Debug register number (0–7) |
| dbg_wdata | input | 32 | Debug write data |
| dbg_rdata | output | 32 | Debug read data (stored value) |

## Verification
The bank-hold properties assume that a debug write aimed at the bank that is not selected is the only way the inactive bank may change. The register-0 and X-index view properties leave out the cycles in which the write port targets the register being watched, because forwarding applies in those cycles. The stimulus drives every input on the falling clock edge and holds `bank_sel` steady across each write edge. It keeps `dbg_we` low except in the tests for R9 and R10, so the hold properties are exercised on nearly every cycle.

// File: rtl/rf_pkg.sv
package rf_pkg;
    localparam int DATA_W     = 32;
    localparam int NUM_ARCH   = 16;
    localparam int NUM_BANKED = 8;
    localparam int NUM_SHARED = NUM_ARCH - NUM_BANKED;
    localparam int ADDR_W     = $clog2(NUM_ARCH);
    localparam int BREG_W     = $clog2(NUM_BANKED);
    localparam int SH_W       = $clog2(NUM_SHARED);

    // fixed register numbers used by the DSP operand port
    localparam int X_BASE = 4;
    localparam int Y_BASE = 6;
    localparam int S_BASE = 2;
    localparam int X_IDX  = 8;
    localparam int Y_IDX  = 9;
    localparam int S_IDX  = 8;

    // read-port slots
    localparam int RP_A     = 0;
    localparam int RP_B     = 1;
    localparam int RP_R0    = 2;
    localparam int RP_XA    = 3;
    localparam int RP_XI    = 4;
    localparam int RP_YA    = 5;
    localparam int RP_YI    = 6;
    localparam int RP_SA    = 7;
    localparam int RP_SI    = 8;
    localparam int NUM_RP   = 9;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] raddr_t;
    typedef logic [BREG_W-1:0] breg_t;
    typedef logic [SH_W-1:0]   shidx_t;

    typedef struct packed {
        word_t [NUM_BANKED-1:0] bank0;
        word_t [NUM_BANKED-1:0] bank1;
        word_t [NUM_SHARED-1:0] shared;
    } rf_state_t;
endpackage

// File: rtl/rf_storage.sv
module rf_storage
    import rf_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      bank_sel,
    input  logic      wr_en,
    input  raddr_t    wr_addr,
    input  word_t     wr_data,
    input  logic      dbg_we,
    input  logic      dbg_bank,
    input  breg_t     dbg_reg,
    input  word_t     dbg_wdata,
    output rf_state_t state_q
);
    rf_state_t state_d;
    breg_t     bidx;
    shidx_t    sidx;

    always_comb begin
        state_d = state_q;
        bidx    = wr_addr[BREG_W-1:0];
        sidx    = shidx_t'(wr_addr - raddr_t'(NUM_BANKED));
        if (wr_en) begin
            if (wr_addr < raddr_t'(NUM_BANKED)) begin
                if (bank_sel) state_d.bank1[bidx] = wr_data;
                else          state_d.bank0[bidx] = wr_data;
            end else begin
                state_d.shared[sidx] = wr_data;
            end
        end
        // debug write applied last so it wins on a collision
        if (dbg_we) begin
            if (dbg_bank) state_d.bank1[dbg_reg] = dbg_wdata;
            else          state_d.bank0[dbg_reg] = dbg_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/rf_view.sv
module rf_view
    import rf_pkg::*;
(
    input  rf_state_t               state_q,
    input  logic                    bank_sel,
    output word_t [NUM_ARCH-1:0]    vis
);
    for (genvar i = 0; i < NUM_ARCH; i++) begin : g_vis
        if (i < NUM_BANKED) begin : g_banked
            assign vis[i] = bank_sel ? state_q.bank1[i] : state_q.bank0[i];
        end else begin : g_shared
            assign vis[i] = state_q.shared[i-NUM_BANKED];
        end
    end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
    import rf_pkg::*;
(
    input  word_t [NUM_ARCH-1:0] vis,
    input  raddr_t               rd_addr,
    input  logic                 wr_en,
    input  raddr_t               wr_addr,
    input  word_t                wr_data,
    output word_t                rd_data
);
    always_comb begin
        if (wr_en && (wr_addr == rd_addr)) rd_data = wr_data;
        else                               rd_data = vis[rd_addr];
    end
endmodule

// File: rtl/rf_dsp_map.sv
module rf_dsp_map
    import rf_pkg::*;
(
    input  logic       x_sel,
    input  logic       y_sel,
    input  logic [1:0] s_sel,
    output raddr_t     xa_num,
    output raddr_t     xi_num,
    output raddr_t     ya_num,
    output raddr_t     yi_num,
    output raddr_t     sa_num,
    output raddr_t     si_num
);
    always_comb begin
        xa_num = raddr_t'(X_BASE) + raddr_t'(x_sel);
        ya_num = raddr_t'(Y_BASE) + raddr_t'(y_sel);
        sa_num = raddr_t'(S_BASE) + raddr_t'(s_sel);
        xi_num = raddr_t'(X_IDX);
        yi_num = raddr_t'(Y_IDX);
        si_num = raddr_t'(S_IDX);
    end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import rf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bank_sel,
    input  logic        wr_en,
    input  logic [3:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic [3:0]  rd_a_addr,
    output logic [31:0] rd_a_data,
    input  logic [3:0]  rd_b_addr,
    output logic [31:0] rd_b_data,
    output logic [31:0] r0_index,
    input  logic        x_sel,
    output logic [31:0] x_addr,
    output logic [31:0] x_index,
    input  logic        y_sel,
    output logic [31:0] y_addr,
    output logic [31:0] y_index,
    input  logic [1:0]  s_sel,
    output logic [31:0] s_addr,
    output logic [31:0] s_index,
    input  logic        dbg_we,
    input  logic        dbg_bank,
    input  logic [2:0]  dbg_reg,
    input  logic [31:0] dbg_wdata,
    output logic [31:0] dbg_rdata
);
    rf_state_t              state_q;
    word_t [NUM_ARCH-1:0]   vis;
    raddr_t [NUM_RP-1:0]    port_num;
    word_t  [NUM_RP-1:0]    port_data;

    rf_storage u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .bank_sel  (bank_sel),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .dbg_we    (dbg_we),
        .dbg_bank  (dbg_bank),
        .dbg_reg   (dbg_reg),
        .dbg_wdata (dbg_wdata),
        .state_q   (state_q)
    );

    rf_view u_view (
        .state_q  (state_q),
        .bank_sel (bank_sel),
        .vis      (vis)
    );

    rf_dsp_map u_map (
        .x_sel  (x_sel),
        .y_sel  (y_sel),
        .s_sel  (s_sel),
        .xa_num (port_num[RP_XA]),
        .xi_num (port_num[RP_XI]),
        .ya_num (port_num[RP_YA]),
        .yi_num (port_num[RP_YI]),
        .sa_num (port_num[RP_SA]),
        .si_num (port_num[RP_SI])
    );

    assign port_num[RP_A]  = rd_a_addr;
    assign port_num[RP_B]  = rd_b_addr;
    assign port_num[RP_R0] = '0;

    for (genvar p = 0; p < NUM_RP; p++) begin : g_rp
        rf_read_port u_rp (
            .vis     (vis),
            .rd_addr (port_num[p]),
            .wr_en   (wr_en),
            .wr_addr (wr_addr),
            .wr_data (wr_data),
            .rd_data (port_data[p])
        );
    end

    assign rd_a_data = port_data[RP_A];
    assign rd_b_data = port_data[RP_B];
    assign r0_index  = port_data[RP_R0];
    assign x_addr    = port_data[RP_XA];
    assign x_index   = port_data[RP_XI];
    assign y_addr    = port_data[RP_YA];
    assign y_index   = port_data[RP_YI];
    assign s_addr    = port_data[RP_SA];
    assign s_index   = port_data[RP_SI];

    assign dbg_rdata = dbg_bank ? state_q.bank1[dbg_reg] : state_q.bank0[dbg_reg];
endmodule

// File: rtl/rf_checker.sv
module rf_checker
    import rf_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        bank_sel,
    input logic        wr_en,
    input logic [3:0]  wr_addr,
    input logic [31:0] wr_data,
    input logic        dbg_we,
    input logic        dbg_bank,
    input logic [3:0]  rd_a_addr,
    input logic [31:0] rd_a_data,
    input logic [31:0] r0_index,
    input logic [31:0] x_index,
    input rf_state_t   state
);
    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (state == '0)); // R1

    AST_BANK1_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!bank_sel && !(dbg_we && dbg_bank)) |=> $stable(state.bank1)); // R4

    AST_BANK0_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_sel && !(dbg_we && !dbg_bank)) |=> $stable(state.bank0)); // R4

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !dbg_we) |=> $stable(state)); // R11

    AST_FWD_A: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == rd_a_addr)) |-> (rd_a_data == wr_data)); // R5

    AST_R0_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (wr_addr == 4'd0)) |->
        (r0_index == (bank_sel ? state.bank1[0] : state.bank0[0]))); // R3

    AST_XIDX_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (wr_addr == 4'd8)) |-> (x_index == state.shared[0])); // R6
endmodule

bind banked_regfile rf_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bank_sel  (bank_sel),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .dbg_we    (dbg_we),
    .dbg_bank  (dbg_bank),
    .rd_a_addr (rd_a_addr),
    .rd_a_data (rd_a_data),
    .r0_index  (r0_index),
    .x_index   (x_index),
    .state     (state_q)
);

// File: tb/banked_regfile_tb.sv
module banked_regfile_tb;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        bank_sel = 0, wr_en = 0, x_sel = 0, y_sel = 0;
    logic [3:0]  wr_addr = 0, rd_a_addr = 0, rd_b_addr = 0;
    logic [31:0] wr_data = 0, dbg_wdata = 0;
    logic [1:0]  s_sel = 0;
    logic        dbg_we = 0, dbg_bank = 0;
    logic [2:0]  dbg_reg = 0;
    logic [31:0] rd_a_data, rd_b_data, r0_index, x_addr, x_index;
    logic [31:0] y_addr, y_index, s_addr, s_index, dbg_rdata;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [31:0] m_b0 [8];
    logic [31:0] m_b1 [8];
    logic [31:0] m_sh [8];

    always #10 clk = ~clk;

    banked_regfile u_dut (.*);

    function automatic logic [31:0] exp_vis(input int b, input int r);
        if (r >= 8) return m_sh[r-8];
        return (b != 0) ? m_b1[r] : m_b0[r];
    endfunction

    function automatic logic [31:0] pat(input int b, input int r);
        return 32'hA500_0000 | (32'(b) << 20) | (32'(r) << 16) | 32'((r * 257) ^ (b * 4097));
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic model_wr(input int b, input int r, input logic [31:0] v);
        if (r >= 8)      m_sh[r-8] = v;
        else if (b != 0) m_b1[r] = v;
        else             m_b0[r] = v;
    endtask

    task automatic do_write(input int b, input int r, input logic [31:0] v);
        @(negedge clk);
        bank_sel = b[0]; wr_addr = 4'(r); wr_data = v; wr_en = 1;
        @(negedge clk);
        wr_en = 0;
        model_wr(b, r, v);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) begin m_b0[i] = 0; m_b1[i] = 0; m_sh[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: all physical registers zero after reset
        for (int b = 0; b < 2; b++)
            for (int r = 0; r < 8; r++) begin
                dbg_bank = b[0]; dbg_reg = 3'(r); #1;
                chk($sformatf("R1 dbg b%0d r%0d", b, r), dbg_rdata, 32'h0);
            end
        for (int a = 8; a < 16; a++) begin
            rd_a_addr = 4'(a); #1;
            chk($sformatf("R1 shared r%0d", a), rd_a_data, 32'h0);
        end

        // fill both banks and the shared registers
        for (int b = 0; b < 2; b++)
            for (int r = 0; r < 16; r++)
                if (b == 0 || r < 8) do_write(b, r, pat(b, r));

        // R2/R3/R6/R7/R8 sweep over both bank settings
        for (int b = 0; b < 2; b++) begin
            @(negedge clk);
            bank_sel = b[0];
            for (int a = 0; a < 16; a++) begin
                rd_a_addr = 4'(a); rd_b_addr = 4'(15 - a); #1;
                chk($sformatf("R2 rdA b%0d a%0d", b, a), rd_a_data, exp_vis(b, a));
                chk($sformatf("R2 rdB b%0d a%0d", b, 15 - a), rd_b_data, exp_vis(b, 15 - a));
            end
            chk($sformatf("R3 r0 b%0d", b), r0_index, exp_vis(b, 0));
            for (int c = 0; c < 2; c++) begin
                x_sel = c[0]; y_sel = c[0]; #1;
                chk($sformatf("R6 xa b%0d c%0d", b, c), x_addr, exp_vis(b, 4 + c));
                chk($sformatf("R6 xi b%0d", b), x_index, exp_vis(b, 8));
                chk($sformatf("R7 ya b%0d c%0d", b, c), y_addr, exp_vis(b, 6 + c));
                chk($sformatf("R7 yi b%0d", b), y_index, exp_vis(b, 9));
            end
            for (int c = 0; c < 4; c++) begin
                s_sel = 2'(c); #1;
                chk($sformatf("R8 sa b%0d c%0d", b, c), s_addr, exp_vis(b, 2 + c));
                chk($sformatf("R8 si b%0d", b), s_index, exp_vis(b, 8));
            end
        end

        // R2: bank switch visible with no clock edge
        @(negedge clk);
        bank_sel = 0; rd_a_addr = 5; #1;
        chk("R2 switch b0", rd_a_data, exp_vis(0, 5));
        bank_sel = 1; #1;
        chk("R2 switch b1", rd_a_data, exp_vis(1, 5));
        chk("R3 switch r0", r0_index, exp_vis(1, 0));

        // R4: inactive bank preserved, shared seen from both
        do_write(1, 2, 32'h1357_9BDF);
        dbg_bank = 0; dbg_reg = 2; #1;
        chk("R4 bank0 kept", dbg_rdata, m_b0[2]);
        dbg_bank = 1; #1;
        chk("R4 bank1 new", dbg_rdata, 32'h1357_9BDF);
        do_write(1, 12, 32'hCAFE_0012);
        @(negedge clk);
        bank_sel = 0; rd_a_addr = 12; #1;
        chk("R4 shared from b0", rd_a_data, 32'hCAFE_0012);

        // R5: forwarding on every output
        @(negedge clk);
        bank_sel = 0; wr_addr = 4; wr_data = 32'hF0F0_0004; wr_en = 1;
        rd_a_addr = 4; rd_b_addr = 4; x_sel = 0; s_sel = 2; #1;
        chk("R5 fwd A", rd_a_data, 32'hF0F0_0004);
        chk("R5 fwd B", rd_b_data, 32'hF0F0_0004);
        chk("R5 fwd X", x_addr, 32'hF0F0_0004);
        chk("R5 fwd S", s_addr, 32'hF0F0_0004);
        @(negedge clk);
        wr_addr = 0; wr_data = 32'h0BAD_0000; #1;
        chk("R5 fwd r0", r0_index, 32'h0BAD_0000);
        model_wr(0, 4, 32'hF0F0_0004);
        @(negedge clk);
        wr_en = 0;
        model_wr(0, 0, 32'h0BAD_0000);
        #1;
        chk("R5 stored A", rd_a_data, 32'hF0F0_0004);
        chk("R3 stored r0", r0_index, 32'h0BAD_0000);
        wr_addr = 9; wr_data = 32'h9999_9999; wr_en = 1; y_sel = 0; #1;
        chk("R5 fwd Yi", y_index, 32'h9999_9999);
        @(negedge clk);
        wr_en = 0; model_wr(0, 9, 32'h9999_9999);

        // R9: debug write to the inactive bank, debug read is not forwarded
        @(negedge clk);
        bank_sel = 0; dbg_we = 1; dbg_bank = 1; dbg_reg = 7; dbg_wdata = 32'hDB61_0007;
        @(negedge clk);
        dbg_we = 0; model_wr(1, 7, 32'hDB61_0007);
        bank_sel = 1; rd_a_addr = 7; #1;
        chk("R9 dbg write b1", rd_a_data, 32'hDB61_0007);
        bank_sel = 0; #1;
        chk("R9 b0 untouched", rd_a_data, m_b0[7]);
        wr_en = 1; wr_addr = 3; wr_data = 32'h3333_0003; dbg_bank = 0; dbg_reg = 3; #1;
        chk("R9 no fwd", dbg_rdata, m_b0[3]);
        @(negedge clk);
        wr_en = 0; model_wr(0, 3, 32'h3333_0003); #1;
        chk("R9 read after", dbg_rdata, 32'h3333_0003);

        // R10: debug write wins a collision
        @(negedge clk);
        bank_sel = 0; wr_en = 1; wr_addr = 6; wr_data = 32'h6666_AAAA;
        dbg_we = 1; dbg_bank = 0; dbg_reg = 6; dbg_wdata = 32'h6666_DDDD;
        @(negedge clk);
        wr_en = 0; dbg_we = 0; model_wr(0, 6, 32'h6666_DDDD); #1;
        chk("R10 dbg wins", dbg_rdata, 32'h6666_DDDD);

        // R11: no write when both enables low
        @(negedge clk);
        wr_addr = 10; wr_data = 32'hDEAD_BEEF; dbg_reg = 1; dbg_bank = 1;
        dbg_wdata = 32'hDEAD_BEEF;
        repeat (2) @(negedge clk);
        rd_a_addr = 10; #1;
        chk("R11 shared kept", rd_a_data, m_sh[2]);
        chk("R11 dbg kept", dbg_rdata, m_b1[1]);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule